// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

A controller-side helper that frees a two-wire serial bus after a protocol interruption, a power loss or a reset. A target device can be left in the middle of a byte with SDA held low. Once a pulse on `start_i` is accepted, the block toggles SCL while keeping SDA released. It checks the data line near the end of every SCL high phase and stops clocking the first time it reads SDA high. It then places a START condition and a STOP condition on the bus and waits out the bus-free time. At the end it pulses `done_o`. If SDA is still low after the last allowed clock pulse, it pulses `fail_o` and places no START or STOP.

Both bus outputs are pull-down enables for open-drain pads: a 1 pulls the line low and a 0 releases it. All phase lengths are parameter counts of the system clock. Two sets of counts exist, one for slow mode and one for fast mode. `fast_i` chooses between them when a run is accepted. `sda_i` must already be synchronised to `clk`.

Top module: `bus_unlock_seq`

## Requirements
- R1: While clocking, SCL is pulled low and released in turn, and SDA is released throughout. No more than MAX_PULSES low/high pulses are made (9 by default).
- R2: SDA is sampled in the last cycle of every SCL high phase. Clocking ends at the first sample that reads high. At least one pulse is always made, so a target that releases SDA during its k-th high phase (1 <= k <= MAX_PULSES) gets exactly k pulses.
- R3: Each clocking low phase lasts the LOW count and each high phase lasts the HIGH count of the selected set. `fast_i`=1 selects the fast set and 0 the slow set. The mode is captured when a run is accepted, and changes to `fast_i` during a run are ignored.
- R4: After a high sample, SCL and SDA stay released for the START-setup count. SDA is then pulled low while SCL is still released (the START) and held for the START-hold count.
- R5: SCL is then pulled low for the LOW count with SDA still low, and released for the STOP-setup count. Next SDA is released while SCL is high (the STOP), and the bus stays free for the BUF count. `done_o` then pulses for one cycle. Counted from the accepting edge, it rises after p*(LOW+HIGH)+SU_STA+HD_STA+LOW+SU_STO+BUF cycles.
- R6: If the MAX_PULSES-th sample still reads low, `fail_o` pulses for one cycle, MAX_PULSES*(LOW+HIGH) cycles after the accepting edge, and no START or STOP is made. `done_o` and `fail_o` are never high together, and both lines are released while either is high.
- R7: In reset and in idle both enables are 0, and so are `busy_o`, `done_o` and `fail_o`. `busy_o` is 1 from the cycle after a run is accepted until the cycle `done_o` or `fail_o` rises. An asynchronous reset in the middle of a run releases both lines.
- R8: A pulse on `start_i` while `busy_o` is 1 is ignored. The run in progress keeps its timing and outcome.
- R9: The two enables never change on the same clock edge. SDA's enable changes only while SCL is released or while SCL has been held low since the START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a recovery run (taken only when idle) |
| fast_i | input | 1 | 1 selects fast timing, 0 slow timing; captured at start |
| sda_i | input | 1 | Synchronised level of the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse: bus freed and left idle |
| fail_o | output | 1 | One-cycle pulse: SDA still low after all clock pulses |

## Verification
The assertions assume that reset is applied before the first active edge and that every timing count is at least one cycle, so each phase takes a whole number of clock cycles. They also assume that `sda_i` only changes after clock edges, as a synchronised line would. The bench keeps to these assumptions. It drives `sda_i` from a model of a stuck target that holds SDA low until it has seen a chosen number of SCL rises, and the model is recomputed only from the registered enables. All other stimulus is applied on falling clock edges.

// File: rtl/bus_unlock_pkg.sv
package bus_unlock_pkg;

    parameter int unsigned TCNT_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_STA_SU,
        ST_STA_HD,
        ST_STO_LO,
        ST_STO_SU,
        ST_BUS_FREE
    } seq_state_e;

    typedef struct packed {
        logic [TCNT_W-1:0] low;
        logic [TCNT_W-1:0] high;
        logic [TCNT_W-1:0] sta_su;
        logic [TCNT_W-1:0] sta_hd;
        logic [TCNT_W-1:0] sto_su;
        logic [TCNT_W-1:0] free;
    } phase_times_t;

endpackage

// File: rtl/bus_unlock_timing_sel.sv
module bus_unlock_timing_sel
    import bus_unlock_pkg::*;
#(
    parameter int unsigned S_LOW    = 120,
    parameter int unsigned S_HIGH   = 60,
    parameter int unsigned S_SU_STA = 60,
    parameter int unsigned S_HD_STA = 60,
    parameter int unsigned S_SU_STO = 60,
    parameter int unsigned S_BUF    = 120,
    parameter int unsigned F_LOW    = 60,
    parameter int unsigned F_HIGH   = 40,
    parameter int unsigned F_SU_STA = 25,
    parameter int unsigned F_HD_STA = 25,
    parameter int unsigned F_SU_STO = 25,
    parameter int unsigned F_BUF    = 50
) (
    input  logic         fast_i,
    output phase_times_t times_o
);

    localparam phase_times_t SLOW_SET = '{
        low:    TCNT_W'(S_LOW),
        high:   TCNT_W'(S_HIGH),
        sta_su: TCNT_W'(S_SU_STA),
        sta_hd: TCNT_W'(S_HD_STA),
        sto_su: TCNT_W'(S_SU_STO),
        free:   TCNT_W'(S_BUF)
    };

    localparam phase_times_t FAST_SET = '{
        low:    TCNT_W'(F_LOW),
        high:   TCNT_W'(F_HIGH),
        sta_su: TCNT_W'(F_SU_STA),
        sta_hd: TCNT_W'(F_HD_STA),
        sto_su: TCNT_W'(F_SU_STO),
        free:   TCNT_W'(F_BUF)
    };

    always_comb begin
        times_o = fast_i ? FAST_SET : SLOW_SET;
    end

endmodule

// File: rtl/bus_unlock_phase_timer.sv
module bus_unlock_phase_timer
    import bus_unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [TCNT_W-1:0] load_val_i,
    output logic              expired_o
);

    logic [TCNT_W-1:0] cnt_d, cnt_q;

    // A load of N keeps the caller in its phase for exactly N cycles.
    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i - TCNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TCNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/bus_unlock_seq.sv
module bus_unlock_seq
    import bus_unlock_pkg::*;
#(
    parameter int unsigned MAX_PULSES = 9,
    parameter int unsigned S_LOW      = 120,
    parameter int unsigned S_HIGH     = 60,
    parameter int unsigned S_SU_STA   = 60,
    parameter int unsigned S_HD_STA   = 60,
    parameter int unsigned S_SU_STO   = 60,
    parameter int unsigned S_BUF      = 120,
    parameter int unsigned F_LOW      = 60,
    parameter int unsigned F_HIGH     = 40,
    parameter int unsigned F_SU_STA   = 25,
    parameter int unsigned F_HD_STA   = 25,
    parameter int unsigned F_SU_STO   = 25,
    parameter int unsigned F_BUF      = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic fast_i,
    input  logic sda_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic busy_o,
    output logic done_o,
    output logic fail_o
);

    localparam int unsigned PW = $clog2(MAX_PULSES + 1);
    localparam logic [PW-1:0] LAST_PULSE = PW'(MAX_PULSES - 1);

    typedef struct packed {
        seq_state_e    state;
        logic          fast;
        logic [PW-1:0] pulses;
        logic          scl_oe;
        logic          sda_oe;
        logic          done;
        logic          fail;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    phase_times_t      times;
    logic              mode_sel;
    logic              tmr_load;
    logic [TCNT_W-1:0] tmr_val;
    logic              tmr_exp;

    // The mode comes from the input only on the accepting cycle.
    assign mode_sel = (r_q.state == ST_IDLE) ? fast_i : r_q.fast;

    bus_unlock_timing_sel #(
        .S_LOW   (S_LOW),    .S_HIGH  (S_HIGH),
        .S_SU_STA(S_SU_STA), .S_HD_STA(S_HD_STA),
        .S_SU_STO(S_SU_STO), .S_BUF   (S_BUF),
        .F_LOW   (F_LOW),    .F_HIGH  (F_HIGH),
        .F_SU_STA(F_SU_STA), .F_HD_STA(F_HD_STA),
        .F_SU_STO(F_SU_STO), .F_BUF   (F_BUF)
    ) u_times (
        .fast_i (mode_sel),
        .times_o(times)
    );

    bus_unlock_phase_timer u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .expired_o (tmr_exp)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.fail = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = times.low;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state  = ST_CLK_LO;
                    r_d.fast   = fast_i;
                    r_d.pulses = '0;
                    r_d.scl_oe = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = times.low;
                end
            end
            ST_CLK_LO: begin
                if (tmr_exp) begin
                    r_d.state  = ST_CLK_HI;
                    r_d.scl_oe = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = times.high;
                end
            end
            ST_CLK_HI: begin
                if (tmr_exp) begin
                    r_d.pulses = r_q.pulses + PW'(1);
                    if (sda_i) begin
                        r_d.state = ST_STA_SU;
                        tmr_load  = 1'b1;
                        tmr_val   = times.sta_su;
                    end else if (r_q.pulses == LAST_PULSE) begin
                        r_d.state = ST_IDLE;
                        r_d.fail  = 1'b1;
                    end else begin
                        r_d.state  = ST_CLK_LO;
                        r_d.scl_oe = 1'b1;
                        tmr_load   = 1'b1;
                        tmr_val    = times.low;
                    end
                end
            end
            ST_STA_SU: begin
                if (tmr_exp) begin
                    r_d.state  = ST_STA_HD;
                    r_d.sda_oe = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = times.sta_hd;
                end
            end
            ST_STA_HD: begin
                if (tmr_exp) begin
                    r_d.state  = ST_STO_LO;
                    r_d.scl_oe = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = times.low;
                end
            end
            ST_STO_LO: begin
                if (tmr_exp) begin
                    r_d.state  = ST_STO_SU;
                    r_d.scl_oe = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = times.sto_su;
                end
            end
            ST_STO_SU: begin
                if (tmr_exp) begin
                    r_d.state  = ST_BUS_FREE;
                    r_d.sda_oe = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = times.free;
                end
            end
            ST_BUS_FREE: begin
                if (tmr_exp) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: begin
                r_d.state  = ST_IDLE;
                r_d.scl_oe = 1'b0;
                r_d.sda_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, fast: 1'b0, pulses: '0,
                     scl_oe: 1'b0, sda_oe: 1'b0, done: 1'b0, fail: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_oe_o = r_q.scl_oe;
    assign sda_oe_o = r_q.sda_oe;
    assign busy_o   = (r_q.state != ST_IDLE);
    assign done_o   = r_q.done;
    assign fail_o   = r_q.fail;

endmodule

// File: rtl/bus_unlock_seq_chk.sv
module bus_unlock_seq_chk #(
    parameter int unsigned MAX_PULSES = 9
) (
    input logic clk,
    input logic rst_n,
    input logic scl_oe_o,
    input logic sda_oe_o,
    input logic busy_o,
    input logic done_o,
    input logic fail_o
);

    localparam int unsigned CW = $clog2(MAX_PULSES + 2) + 1;

    logic          scl_prev_q;
    logic [CW-1:0] clk_lows_q;

    // Counts SCL pull-downs made with SDA released during one run.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b0;
            clk_lows_q <= '0;
        end else begin
            scl_prev_q <= scl_oe_o;
            if (!busy_o) begin
                clk_lows_q <= '0;
            end else if (scl_oe_o && !scl_prev_q && !sda_oe_o) begin
                clk_lows_q <= clk_lows_q + CW'(1);
            end
        end
    end

    assert_pulse_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clk_lows_q <= CW'(MAX_PULSES));

    assert_start_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_oe_o);

    assert_stop_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe_o) |-> !scl_oe_o);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_end_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |-> (!scl_oe_o && !sda_oe_o && !(done_o && fail_o)));

    assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_oe_o && !sda_oe_o));

    assert_one_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe_o != $past(scl_oe_o)) |-> $stable(sda_oe_o));

endmodule

bind bus_unlock_seq bus_unlock_seq_chk #(
    .MAX_PULSES(MAX_PULSES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_oe_o(scl_oe_o),
    .sda_oe_o(sda_oe_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .fail_o  (fail_o)
);

// File: tb/bus_unlock_seq_bench.sv
module bus_unlock_seq_bench;

    localparam int MAXP = 9;
    localparam int SL = 12, SH = 6, SSU = 6, SHD = 6, SSTO = 6, SBF = 12;
    localparam int FL = 6,  FH = 4, FSU = 3, FHD = 3, FSTO = 3, FBF = 5;

    // Vector table: mode, SCL rise at which the target lets go, glitch cycle.
    localparam int NV = 9;
    localparam bit VF [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam int VK [NV] = '{0,    1,    3,    5,    9,    9,    10,   12,   4};
    localparam int VG [NV] = '{0,    0,    0,    0,    0,    0,    0,    0,    5};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic fast_i = 1'b0;
    logic sda_i;
    logic scl_oe_o, sda_oe_o, busy_o, done_o, fail_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  hold_k  = 0;
    int  rises   = 0;
    logic clr_rise = 1'b0;

    always #4 clk = ~clk;

    bus_unlock_seq #(
        .MAX_PULSES(MAXP),
        .S_LOW(SL), .S_HIGH(SH), .S_SU_STA(SSU), .S_HD_STA(SHD), .S_SU_STO(SSTO), .S_BUF(SBF),
        .F_LOW(FL), .F_HIGH(FH), .F_SU_STA(FSU), .F_HD_STA(FHD), .F_SU_STO(FSTO), .F_BUF(FBF)
    ) u_bus_unlock_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fast_i(fast_i), .sda_i(sda_i),
        .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .busy_o(busy_o),
        .done_o(done_o), .fail_o(fail_o)
    );

    // Stuck target: holds SDA low until it has seen hold_k SCL rises.
    always @(posedge clr_rise or negedge scl_oe_o) begin
        if (clr_rise) rises <= 0;
        else          rises <= rises + 1;
    end
    assign sda_i = ~sda_oe_o & (rises >= hold_k);

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_case(input bit fast, input int k, input int glitch);
        int L, H, SU, HD, STO, BF, p, exp_lat, cyc, lat, run;
        int minlow, minhigh, releases, starts, stops, exp_minhigh;
        bit fail_exp, got_done, got_fail, lvl, first_high, prev_sda, prev_scl;
        L  = fast ? FL  : SL;   H  = fast ? FH  : SH;
        SU = fast ? FSU : SSU;  HD = fast ? FHD : SHD;
        STO = fast ? FSTO : SSTO; BF = fast ? FBF : SBF;
        fail_exp = (k > MAXP);
        p = fail_exp ? MAXP : ((k < 1) ? 1 : k);
        exp_lat = fail_exp ? p * (L + H) : p * (L + H) + SU + HD + L + STO + BF;
        exp_minhigh = (fail_exp || p >= 2) ? H : H + SU + HD;

        hold_k = k;
        clr_rise = 1'b1;
        @(negedge clk);
        clr_rise = 1'b0;
        fast_i  = fast;
        start_i = 1'b1;
        cyc = 0; lat = 0; run = 0; lvl = 1'b0; first_high = 1'b1;
        prev_sda = 1'b0; prev_scl = 1'b0;
        minlow = 1000000; minhigh = 1000000; releases = 0; starts = 0; stops = 0;
        got_done = 1'b0; got_fail = 1'b0;
        while (!got_done && !got_fail && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            start_i = 1'b0;
            if (glitch != 0 && cyc == glitch) begin
                start_i = 1'b1;       // R8: ignored while busy
                fast_i  = ~fast;      // R3: mode change during a run ignored
            end
            if (cyc == 2) chk("R7 busy during run", int'(busy_o), 1);
            if (scl_oe_o != lvl) begin
                if (lvl) begin
                    if (run < minlow) minlow = run;
                    releases++;
                end else if (!first_high) begin
                    if (run < minhigh) minhigh = run;
                end
                first_high = 1'b0;
                lvl = scl_oe_o;
                run = 1;
            end else begin
                run++;
            end
            if (sda_oe_o && !prev_sda && !scl_oe_o && !prev_scl) starts++;
            if (!sda_oe_o && prev_sda && !scl_oe_o && !prev_scl) stops++;
            prev_sda = sda_oe_o;
            prev_scl = scl_oe_o;
            if (done_o) begin got_done = 1'b1; lat = cyc; end
            if (fail_o) begin got_fail = 1'b1; lat = cyc; end
        end
        chk("R5/R6 done outcome", int'(got_done), int'(!fail_exp));
        chk("R6 fail outcome", int'(got_fail), int'(fail_exp));
        chk(fail_exp ? "R6 fail latency" : "R5 done latency", lat, exp_lat + 1);
        chk("R1/R2 SCL releases", releases, p + (fail_exp ? 0 : 1));
        chk("R4 START count", starts, fail_exp ? 0 : 1);
        chk("R5 STOP count", stops, fail_exp ? 0 : 1);
        chk("R3 min low phase", minlow, L);
        chk("R3 min high phase", minhigh, exp_minhigh);
        @(negedge clk);
        chk("R5 one-cycle done/fail", int'(done_o | fail_o), 0);
        chk("R7 idle after run", int'(busy_o | scl_oe_o | sda_oe_o), 0);
        fast_i = 1'b0;
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            begin
                repeat (3) @(negedge clk);
                chk("R7 reset scl_oe", int'(scl_oe_o), 0);
                chk("R7 reset sda_oe", int'(sda_oe_o), 0);
                chk("R7 reset busy", int'(busy_o), 0);
                chk("R7 reset done/fail", int'(done_o | fail_o), 0);
                rst_n = 1'b1;
                repeat (2) @(negedge clk);

                for (int i = 0; i < NV; i++) begin
                    run_case(VF[i], VK[i], VG[i]);
                end

                // Directed: reset in the middle of a stuck run releases lines.
                hold_k = 100;
                fast_i = 1'b0;
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                repeat (20) @(negedge clk);
                rst_n = 1'b0;
                @(negedge clk);
                chk("R7 mid-run reset lines", int'(scl_oe_o | sda_oe_o), 0);
                chk("R7 mid-run reset busy", int'(busy_o), 0);
                rst_n = 1'b1;
                @(negedge clk);

                // Directed: recovery after that reset, target already free.
                run_case(1'b1, 0, 0);
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule